// File: doc/BRIEF.md
# Audio DMA Request Generator

This block raises DMA requests for one audio channel, sitting between a sample FIFO and a host DMA controller. The host programs a byte count and a transfer mode through a small register write port. When the channel is enabled and the FIFO can take or give a whole burst, the block asserts its request. It counts acknowledged byte strobes against the burst length, and a 16-bit transfer counter tracks every byte moved.

When the transfer counter passes zero it reloads from the programmed value and sets an interrupt flag. In auto-initialize mode requests then continue. In normal mode the block clears its own enable bit and stays idle until the host enables it again. An optional latch keeps a request high, once raised, until the controller acknowledges it.

Top module: `audio_dma_req`

## Requirements
- R1: After reset `drq_o` and `irq_o` are low, and every register field is zero.
- R2: A request is raised only while the enable bit (register 2 bit 0) is set, `fifo_ready_i` is high and `fifo_level_i` is at least the burst length. The burst field (register 2 bits 7:6) sets that length: 00 gives 1 byte (single transfer), 01 gives 2, 10 gives 4 and 11 gives 8 bytes.
- R3: A byte counts only when `dack_i` and `xfer_strobe_i` are both high while `drq_o` is high. `drq_o` falls on the clock edge at which the byte completing the burst is counted.
- R4: Writing register 0 stores the low byte of the reload value. Writing register 1 stores the high byte and loads the counter with the full value. A transfer then lasts value+1 bytes, and rollover happens on the byte counted while the counter is zero.
- R5: With auto-initialize set (register 2 bit 4 = 1), rollover reloads the counter and requests continue without host action.
- R6: With auto-initialize clear, rollover reloads the counter, clears the enable bit and ends the request. `drq_o` then stays low until the host writes the enable bit again.
- R7: Rollover sets an interrupt flag. `irq_o` is the flag gated by the interrupt enable (register 2 bit 1). Any write to register 3 clears the flag, and a rollover in the same cycle wins.
- R8: With the latch bit (register 2 bit 2) set, a raised request holds until a byte is acknowledged, even if the FIFO condition goes away. With the latch bit clear, a request with no acknowledged byte yet falls one clock after the FIFO condition fails.
- R9: Clearing the enable bit drops `drq_o` by the next clock edge and leaves the counter unchanged, so the transfer resumes where it stopped when enabled again.
- R10: A strobe without `dack_i`, or `dack_i` without a strobe, does not change the counter or the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 reload low, 1 reload high, 2 mode, 3 flag clear |
| reg_wdata_i | input | 8 | Register write data |
| fifo_ready_i | input | 1 | FIFO can serve DMA |
| fifo_level_i | input | LVL_W | Bytes the FIFO can accept or supply |
| dack_i | input | 1 | DMA acknowledge from the controller |
| xfer_strobe_i | input | 1 | Byte transfer strobe |
| drq_o | output | 1 | DMA request |
| irq_o | output | 1 | Channel interrupt |

## Verification
A wrong burst counter shows at once as a request that stays high for the wrong number of acknowledged bytes. A wrong transfer counter shows up later, as an interrupt after the wrong total byte count. A counter that drifts while the channel is disabled or while strobes lack an acknowledge only appears at the next rollover. For that reason the bench counts bytes across pauses and compares the total with the programmed length. Because the reference model is compared on every clock, a fault in the enable, latch or flag state is reported within the cycle in which `drq_o` or `irq_o` differs.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef enum logic [1:0] {
    XFER_SINGLE = 2'b00,
    XFER_DEM2   = 2'b01,
    XFER_DEM4   = 2'b10,
    XFER_DEM8   = 2'b11
  } xfer_e;

  function automatic logic [3:0] burst_len(input xfer_e m);
    return 4'd1 << m;
  endfunction
endpackage

// File: rtl/adm_regs.sv
module adm_regs
  import adm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             tc_i,
  output logic [CNT_W-1:0] reload_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output xfer_e            mode_o,
  output logic             auto_o,
  output logic             en_o,
  output logic             irq_en_o,
  output logic             latch_o,
  output logic             flag_o
);
  localparam int HI_W = CNT_W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  xfer_e           mode_q;
  logic            auto_q, en_q, irq_en_q, latch_q, flag_q;
  logic            wr_lo, wr_hi, wr_mode, wr_ack;

  assign wr_lo   = we_i && (addr_i == 2'd0);
  assign wr_hi   = we_i && (addr_i == 2'd1);
  assign wr_mode = we_i && (addr_i == 2'd2);
  assign wr_ack  = we_i && (addr_i == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      mode_q   <= XFER_SINGLE;
      auto_q   <= 1'b0;
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      latch_q  <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wdata_i;
      if (wr_hi) hi_q <= wdata_i[HI_W-1:0];
      if (wr_mode) begin
        mode_q   <= xfer_e'(wdata_i[7:6]);
        auto_q   <= wdata_i[4];
        latch_q  <= wdata_i[2];
        irq_en_q <= wdata_i[1];
        en_q     <= wdata_i[0];
      end else if (tc_i && !auto_q) begin
        en_q <= 1'b0;  // normal mode stops itself
      end
      if (tc_i)        flag_q <= 1'b1;
      else if (wr_ack) flag_q <= 1'b0;
    end
  end

  assign reload_o   = {hi_q, lo_q};
  assign load_o     = wr_hi;
  assign load_val_o = {wdata_i[HI_W-1:0], lo_q};
  assign mode_o     = mode_q;
  assign auto_o     = auto_q;
  assign en_o       = en_q;
  assign irq_en_o   = irq_en_q;
  assign latch_o    = latch_q;
  assign flag_o     = flag_q;

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> flag_q);
  assert_normal_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i && !auto_q && !wr_mode |=> !en_q);
endmodule

// File: rtl/adm_counter.sv
module adm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             byte_i,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tc_o = byte_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (byte_i)  cnt_q <= tc_o ? reload_i : cnt_q - 1'b1;
  end

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o && !load_i |=> cnt_q == $past(reload_i));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_i && !load_i |=> $stable(cnt_q));
endmodule

// File: rtl/adm_burst.sv
module adm_burst
  import adm_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  xfer_e            mode_i,
  input  logic             latch_i,
  input  logic             fifo_ready_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             dack_i,
  input  logic             strobe_i,
  input  logic             tc_i,
  output logic             drq_o,
  output logic             byte_o
);
  logic [3:0] len;
  logic [2:0] beat_q;
  logic       drq_q, acked_q, can_go, last;

  assign len    = burst_len(mode_i);
  assign can_go = fifo_ready_i && (fifo_level_i >= LVL_W'(len));
  assign last   = (beat_q == 3'(len - 4'd1));
  assign byte_o = drq_q && dack_i && strobe_i;
  assign drq_o  = drq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drq_q   <= 1'b0;
      beat_q  <= '0;
      acked_q <= 1'b0;
    end else if (!en_i) begin
      drq_q   <= 1'b0;
      beat_q  <= '0;
      acked_q <= 1'b0;
    end else if (drq_q) begin
      if (byte_o) begin
        if (last || tc_i) begin
          drq_q   <= 1'b0;
          beat_q  <= '0;
          acked_q <= 1'b0;
        end else begin
          beat_q  <= beat_q + 1'b1;
          acked_q <= 1'b1;
        end
      end else if (!acked_q && !latch_i && !can_go) begin
        drq_q <= 1'b0;  // unlatched request withdrawn
      end
    end else if (can_go) begin
      drq_q  <= 1'b1;
      beat_q <= '0;
    end
  end

  assert_rise_needs_room_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drq_q) |-> $past(can_go) && $past(en_i));
  assert_burst_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_o && last |=> !drq_q);
  assert_drop_on_disable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !drq_q);
  assert_latch_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drq_q && latch_i && en_i && !byte_o |=> drq_q);
endmodule

// File: rtl/audio_dma_req.sv
module audio_dma_req
  import adm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  input  logic             fifo_ready_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             dack_i,
  input  logic             xfer_strobe_i,
  output logic             drq_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] reload, load_val;
  logic             load, auto_mode, en, irq_en, latch, flag, tc, byte_ok;
  xfer_e            mode;

  adm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .tc_i(tc),
    .reload_o(reload), .load_o(load), .load_val_o(load_val),
    .mode_o(mode), .auto_o(auto_mode), .en_o(en), .irq_en_o(irq_en),
    .latch_o(latch), .flag_o(flag)
  );

  adm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(load_val), .reload_i(reload),
    .byte_i(byte_ok), .tc_o(tc)
  );

  adm_burst #(.LVL_W(LVL_W)) u_burst (
    .clk_i, .rst_ni,
    .en_i(en), .mode_i(mode), .latch_i(latch),
    .fifo_ready_i, .fifo_level_i,
    .dack_i, .strobe_i(xfer_strobe_i), .tc_i(tc),
    .drq_o, .byte_o(byte_ok)
  );

  assign irq_o = flag && irq_en;

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en);
endmodule

// File: tb/audio_dma_req_tb.sv
`timescale 1ns/1ps
module audio_dma_req_tb;
  logic       clk = 0, rst_n = 0;
  logic       we = 0, ready = 0, dack = 0, strobe = 0, agent_on = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [4:0] level = 0;
  logic       drq, irq;
  int checks = 0, fails = 0, nbytes = 0;

  always #10 clk = ~clk;

  audio_dma_req u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .fifo_ready_i(ready), .fifo_level_i(level),
    .dack_i(dack), .xfer_strobe_i(strobe), .drq_o(drq), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_en, m_irqen, m_latch, m_auto, m_mode, m_lo, m_hi, m_cnt, m_flag, m_drq, m_beat, m_acked;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_irqen = 0; m_latch = 0; m_auto = 0; m_mode = 0; m_lo = 0; m_hi = 0;
      m_cnt = 0; m_flag = 0; m_drq = 0; m_beat = 0; m_acked = 0;
    end else begin : step
      int len, n_drq, n_beat, n_acked;
      bit go, bo, tc;
      len = 1 << m_mode;
      go  = ready && (level >= len);
      bo  = m_drq && dack && strobe;
      tc  = bo && (m_cnt == 0);
      n_drq = m_drq; n_beat = m_beat; n_acked = m_acked;
      if (!m_en) begin n_drq = 0; n_beat = 0; n_acked = 0; end
      else if (m_drq) begin
        if (bo) begin
          if (m_beat == len - 1 || tc) begin n_drq = 0; n_beat = 0; n_acked = 0; end
          else begin n_beat = m_beat + 1; n_acked = 1; end
        end else if (!m_acked && !m_latch && !go) n_drq = 0;
      end else if (go) begin n_drq = 1; n_beat = 0; end
      if (we && addr == 1) m_cnt = wdata * 256 + m_lo;
      else if (bo) m_cnt = tc ? m_hi * 256 + m_lo : m_cnt - 1;
      if (tc) m_flag = 1; else if (we && addr == 3) m_flag = 0;
      if (we && addr == 0) m_lo = wdata;
      if (we && addr == 1) m_hi = wdata;
      if (we && addr == 2) begin
        m_mode = wdata[7:6]; m_auto = wdata[4]; m_latch = wdata[2];
        m_irqen = wdata[1]; m_en = wdata[0];
      end else if (tc && !m_auto) m_en = 0;
      m_drq = n_drq; m_beat = n_beat; m_acked = n_acked;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(drq === 1'(m_drq), "R2 drq vs model", drq, m_drq);
    chk(irq === 1'(m_flag && m_irqen), "R7 irq vs model", irq, m_flag && m_irqen);
  end

  // DMA controller emulation: acknowledge every cycle a request is seen
  always @(posedge clk) begin
    #1;
    if (agent_on) begin dack = drq; strobe = drq; end
  end
  always @(posedge clk) if (dack && strobe && drq) nbytes++;

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2; we = 1; addr = a; wdata = d;
    @(posedge clk); #2; we = 0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
    chk(irq === 1'b1, req, irq, 1);
  endtask

  task automatic max_run(input int cycles, output int best);
    int run = 0;
    best = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (drq) begin run++; if (run > best) best = run; end else run = 0;
    end
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int best, held;
    repeat (3) @(negedge clk);
    chk(drq === 1'b0, "R1 reset drq", drq, 0);
    chk(irq === 1'b0, "R1 reset irq", irq, 0);
    rst_n = 1;
    level = 16; ready = 1;

    // R4 R6 R7: 6-byte single transfer, normal mode
    wr(0, 5); wr(1, 0);
    nbytes = 0; agent_on = 1;
    wr(2, 8'b0000_0011);
    wait_irq("R7 irq on rollover");
    chk(nbytes == 6, "R4 bytes per transfer", nbytes, 6);
    repeat (10) @(negedge clk);
    chk(drq === 1'b0, "R6 halted after rollover", drq, 0);
    chk(nbytes == 6, "R6 no bytes after halt", nbytes, 6);
    wr(3, 0); @(negedge clk);
    chk(irq === 1'b0, "R7 flag clear", irq, 0);

    // R3: burst lengths
    wr(0, 8'hff); wr(1, 0);
    wr(2, 8'b1001_0001);
    max_run(30, best);
    chk(best == 4, "R3 demand-4 burst", best, 4);
    wr(2, 0);
    wr(2, 8'b1101_0001);
    max_run(30, best);
    chk(best == 8, "R3 demand-8 burst", best, 8);
    wr(2, 0);
    wr(2, 8'b0101_0001);
    max_run(30, best);
    chk(best == 2, "R3 demand-2 burst", best, 2);

    // R5: auto-init continues after rollover
    wr(2, 0); wr(3, 0);
    wr(0, 31); wr(1, 0);
    wr(2, 8'b1101_0011);
    wait_irq("R5 first rollover");
    wr(3, 0);
    max_run(12, best);
    chk(best > 0, "R5 requests continue", best, 1);
    wait_irq("R5 second rollover");
    wr(2, 0); wr(3, 0);

    // R2: level below burst size
    agent_on = 0; dack = 0; strobe = 0;
    level = 3;
    wr(2, 8'b1000_0001);
    max_run(10, best);
    chk(best == 0, "R2 no request below burst size", best, 0);
    level = 4;
    repeat (2) @(negedge clk);
    chk(drq === 1'b1, "R2 request at burst size", drq, 1);
    wr(2, 0);

    // R8: latched request holds, unlatched is withdrawn
    level = 16;
    wr(2, 8'b1000_0101);
    repeat (2) @(negedge clk);
    ready = 0;
    repeat (3) @(negedge clk);
    chk(drq === 1'b1, "R8 latched hold", drq, 1);
    wr(2, 0); ready = 1;
    wr(2, 8'b1000_0001);
    repeat (2) @(negedge clk);
    ready = 0;
    repeat (2) @(negedge clk);
    chk(drq === 1'b0, "R8 unlatched drop", drq, 0);
    wr(2, 0); ready = 1;

    // R9: disable mid transfer, counter holds
    wr(3, 0);
    wr(0, 9); wr(1, 0);
    nbytes = 0; agent_on = 1;
    wr(2, 8'b0000_0011);
    while (nbytes < 4) @(negedge clk);
    @(posedge clk); #2; we = 1; addr = 2; wdata = 8'b0000_0010;
    @(posedge clk); #2; we = 0;
    @(negedge clk);
    chk(drq === 1'b0, "R9 drop on disable", drq, 0);
    held = nbytes;
    repeat (5) @(negedge clk);
    chk(nbytes == held, "R9 idle while disabled", nbytes, held);
    wr(2, 8'b0000_0011);
    wait_irq("R9 resumed rollover");
    chk(nbytes == 10, "R9 count kept across pause", nbytes, 10);
    wr(2, 0); wr(3, 0);

    // R10: unqualified strobes ignored
    agent_on = 0; dack = 0; strobe = 0;
    wr(0, 2); wr(1, 0);
    wr(2, 8'b0000_0011);
    @(posedge clk); #2; strobe = 1; dack = 0;
    repeat (5) @(posedge clk);
    #2; strobe = 0; dack = 1;
    repeat (3) @(posedge clk);
    #2; dack = 0;
    @(negedge clk);
    chk(irq === 1'b0, "R10 no rollover from stray strobes", irq, 0);
    chk(drq === 1'b1, "R10 request still pending", drq, 1);
    nbytes = 0; agent_on = 1;
    wait_irq("R10 rollover");
    chk(nbytes == 3, "R10 full count remains", nbytes, 3);

    agent_on = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule